// File: doc/BRIEF.md
# Three-Stage Counter Reduction Tree for Unsigned Multiplication

This block is the purely combinational front half of an unsigned multiplier. It takes two operands of `WIDTH` bits (32 by default), forms every partial-product bit as a single AND of one bit from each operand, and groups those bits by weight into columns. Three compression stages then bring the columns down to two rows of `2*WIDTH` bits. The carry-propagate adder that sums the two rows sits outside the block.

The first stage cuts each column into groups. A group with eight or more bits goes to a 15-input counter. A group of four to seven bits goes to a 7-input counter. A group of three bits goes to a full adder, and one or two leftover bits pass through unchanged. This leaves no column taller than ten bits for operands of up to 32 bits. The second stage uses the same counter types, plus a full adder with a zero input for two-bit columns, so that every column emits exactly one bit of its own weight. After it no column is taller than four. The third stage is a row of 4:2 compressors. Each sends its intermediate carry sideways into the next column, so the result is exactly two rows. A counter output of weight 2^k taken from column c lands in column c+k of the next stage. Bits of weight 2^(2*WIDTH) or above are dropped, so the rows are exact modulo 2^(2*WIDTH). Counter inputs that a column does not fill are tied to 0. `WIDTH` may range from 4 to 32.

Top module: `mul_reduce3`

## Requirements
- R1: For every pair of operands, `row_s + row_c` taken modulo 2^(2*WIDTH) equals `op_a * op_b`.
- R2: When either operand is zero, both `row_s` and `row_c` are all zeros.
- R3: When `op_b` is 1, the two rows sum to `op_a`. When `op_a` is 1, they sum to `op_b`.
- R4: Bit 0 of `row_c` is always 0, because compressor carries only land one column up.
- R5: Bit 0 of `row_s` always equals `op_a[0] & op_b[0]`, the lone weight-1 partial product.
- R6: With both operands all ones, the rows sum to (2^WIDTH - 1)^2, which is 64'hFFFFFFFE00000001 at WIDTH = 32.
- R7: Swapping the two operands leaves the sum of the rows unchanged.
- R8: For operands 2^i and 2^j, the rows sum to 2^(i+j) for every i and j below WIDTH, including the top column 2*WIDTH-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| row_s | output | 2*WIDTH | First reduced row (compressor sums) |
| row_c | output | 2*WIDTH | Second reduced row (compressor carries, shifted up one column) |

## Verification
Two things meet in the same column at once: the weight-2 and weight-3 outputs of counters in lower columns, and that column's own counter and pass-through bits. On top of that, the sideways carry of the 4:2 compressor below arrives there too. Dense operands push all of these to their worst case together. All-ones and alternating patterns do this at 32 bits, and an exhaustive sweep of every operand pair does it at 8 bits. Each case is judged by adding the two rows in the bench and comparing the sum with an arithmetic product. Single-bit operands instead light one column alone, which shows that each counter output is routed to the correct higher column.

// File: rtl/mul_reduce3.sv
module mul_reduce3 #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] row_s,
  output logic [2*WIDTH-1:0] row_c
);
  localparam int COLS    = 2 * WIDTH;
  localparam int H1      = 10;
  localparam int H2      = 4;
  localparam int GROUPS1 = WIDTH / 15 + 1;

  logic [WIDTH-1:0] col0 [COLS];
  logic [H1-1:0]    col1 [COLS];
  logic [3:0]       ht1  [COLS];
  logic [H2-1:0]    col2 [COLS];

  function automatic int grp_take(input int r, input int fa_min);
    if (r >= 8)           return (r > 15) ? 15 : r;
    else if (r >= fa_min) return r;
    else                  return 0;
  endfunction

  function automatic int grp_outs(input int t);
    return (t >= 8) ? 4 : (t >= 4) ? 3 : 2;
  endfunction

  // partial products, packed per column from slot 0
  always_comb begin : pp_gen
    int lo, hi;
    lo = 0; hi = 0;
    for (int c = 0; c < COLS; c++) begin
      col0[c] = '0;
      lo = (c > WIDTH - 1) ? c - WIDTH + 1 : 0;
      hi = (c < WIDTH - 1) ? c : WIDTH - 1;
      for (int k = 0; k < WIDTH; k++)
        if (k >= lo && k <= hi) col0[c][k-lo] = op_a[k] & op_b[c-k];
    end
  end

  // stage one: (15,4), (7,3), full adders, pass of up to two bits
  always_comb begin : stage_one
    int lo, hi, h, base, t, no;
    int fill [COLS];
    logic [3:0] sm;
    lo = 0; hi = 0; h = 0; base = 0; t = 0; no = 0; sm = '0;
    for (int c = 0; c < COLS; c++) begin
      col1[c] = '0;
      fill[c] = 0;
    end
    for (int c = 0; c < COLS; c++) begin
      lo = (c > WIDTH - 1) ? c - WIDTH + 1 : 0;
      hi = (c < WIDTH - 1) ? c : WIDTH - 1;
      h  = (hi >= lo) ? hi - lo + 1 : 0;
      base = 0;
      for (int g = 0; g < GROUPS1; g++) begin
        t = grp_take(h - base, 3);
        if (t > 0) begin
          sm = '0;
          for (int k = 0; k < 15; k++)
            if (k < t) sm = sm + 4'(col0[c][base+k]);
          no = grp_outs(t);
          for (int b = 0; b < 4; b++)
            if (b < no && c + b < COLS) begin
              col1[c+b][fill[c+b]] = sm[b];
              fill[c+b] = fill[c+b] + 1;
            end
          base = base + t;
        end
      end
      for (int k = 0; k < 2; k++)
        if (base + k < h) begin
          col1[c][fill[c]] = col0[c][base+k];
          fill[c] = fill[c] + 1;
        end
    end
    for (int c = 0; c < COLS; c++) ht1[c] = 4'(fill[c]);
  end

  // stage two: one counter per column of height two or more
  always_comb begin : stage_two
    int h, t, no;
    int fill [COLS];
    logic [3:0] sm;
    h = 0; t = 0; no = 0; sm = '0;
    for (int c = 0; c < COLS; c++) begin
      col2[c] = '0;
      fill[c] = 0;
    end
    for (int c = 0; c < COLS; c++) begin
      h = int'(ht1[c]);
      t = grp_take(h, 2);
      if (t > 0) begin
        sm = '0;
        for (int k = 0; k < H1; k++)
          if (k < t) sm = sm + 4'(col1[c][k]);
        no = grp_outs(t);
        for (int b = 0; b < 4; b++)
          if (b < no && c + b < COLS) begin
            col2[c+b][fill[c+b]] = sm[b];
            fill[c+b] = fill[c+b] + 1;
          end
      end else if (h == 1) begin
        col2[c][fill[c]] = col1[c][0];
        fill[c] = fill[c] + 1;
      end
    end
  end

  // stage three: 4:2 compressors with a sideways carry
  always_comb begin : stage_three
    logic cy, s1, co;
    cy = 1'b0; s1 = 1'b0; co = 1'b0;
    row_s = '0;
    row_c = '0;
    for (int c = 0; c < COLS; c++) begin
      s1 = col2[c][0] ^ col2[c][1] ^ col2[c][2];
      co = (col2[c][0] & col2[c][1]) | (col2[c][0] & col2[c][2]) | (col2[c][1] & col2[c][2]);
      row_s[c] = s1 ^ col2[c][3] ^ cy;
      if (c + 1 < COLS)
        row_c[c+1] = (s1 & col2[c][3]) | (s1 & cy) | (col2[c][3] & cy);
      cy = co;
    end
  end
endmodule

// File: rtl/mul_reduce3_props.sv
module mul_reduce3_props #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic [2*WIDTH-1:0] row_s,
  input logic [2*WIDTH-1:0] row_c
);
  localparam int COLS = 2 * WIDTH;
  logic [COLS-1:0] want;
  logic [COLS-1:0] got;
  assign want = COLS'(op_a) * COLS'(op_b);
  assign got  = row_s + row_c;

  always_comb begin
    if (!$isunknown({op_a, op_b, row_s, row_c})) begin
      assert_product_R1: assert (got == want)
        else $error("rows sum %h, product %h", got, want);
      assert_zero_rows_R2: assert (!(op_a == '0 || op_b == '0) || (row_s == '0 && row_c == '0))
        else $error("nonzero rows for zero operand");
      assert_identity_R3: assert (op_b != WIDTH'(1) || got == COLS'(op_a))
        else $error("multiply by one gives %h", got);
      assert_lsb_carry_R4: assert (row_c[0] == 1'b0)
        else $error("carry row bit 0 set");
      assert_lsb_sum_R5: assert (row_s[0] == (op_a[0] & op_b[0]))
        else $error("sum row bit 0 wrong");
    end
  end
endmodule

bind mul_reduce3 mul_reduce3_props #(.WIDTH(WIDTH)) u_props (
  .op_a(op_a), .op_b(op_b), .row_s(row_s), .row_c(row_c)
);

// File: tb/mul_reduce3_test.sv
module mul_reduce3_test;
  localparam int WB = 32;
  localparam int WS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [WB-1:0]   a, b;
  logic [2*WB-1:0] rs, rc;
  logic [WS-1:0]   sa, sb;
  logic [2*WS-1:0] srs, src;

  mul_reduce3 #(.WIDTH(WB)) uut (.op_a(a), .op_b(b), .row_s(rs), .row_c(rc));
  mul_reduce3 #(.WIDTH(WS)) uut_small (.op_a(sa), .op_b(sb), .row_s(srs), .row_c(src));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [WB-1:0] x, input logic [WB-1:0] y);
    @(posedge clk);
    a = x; b = y;
    @(negedge clk);
  endtask

  task automatic mul_chk(input string tag, input logic [WB-1:0] x, input logic [WB-1:0] y);
    logic [63:0] exp;
    drive(x, y);
    exp = 64'(x) * 64'(y);
    chk(tag, rs + rc, exp);
    chk("R4", {63'b0, rc[0]}, 64'd0);
    chk("R5", {63'b0, rs[0]}, {63'b0, x[0] & y[0]});
  endtask

  initial begin
    a = '0; b = '0; sa = '0; sb = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 reset rows_s", rs, 64'd0);
    chk("R2 reset rows_c", rc, 64'd0);

    // R2: zero on either side
    for (int n = 0; n < 50; n++) begin
      drive('0, $urandom);
      chk("R2 a=0 row_s", rs, 64'd0);
      chk("R2 a=0 row_c", rc, 64'd0);
      drive($urandom, '0);
      chk("R2 b=0 row_s", rs, 64'd0);
      chk("R2 b=0 row_c", rc, 64'd0);
    end

    // R3: identity
    for (int n = 0; n < 50; n++) begin
      logic [WB-1:0] x;
      x = $urandom;
      drive(x, 32'd1);
      chk("R3 b=1", rs + rc, 64'(x));
      drive(32'd1, x);
      chk("R3 a=1", rs + rc, 64'(x));
    end

    // R6 and dense patterns (R1)
    drive('1, '1);
    chk("R6 all ones", rs + rc, 64'hFFFFFFFE00000001);
    mul_chk("R1 alt A*5", 32'hAAAAAAAA, 32'h55555555);
    mul_chk("R1 alt A*A", 32'hAAAAAAAA, 32'hAAAAAAAA);
    mul_chk("R1 alt 5*5", 32'h55555555, 32'h55555555);
    mul_chk("R1 ones*alt", 32'hFFFFFFFF, 32'hAAAAAAAA);
    mul_chk("R1 top bits", 32'h80000000, 32'hFFFFFFFF);

    // R8: single-bit operands across every column
    for (int i = 0; i < WB; i++)
      for (int j = 0; j < WB; j++) begin
        drive(32'd1 << i, 32'd1 << j);
        chk("R8 power of two", rs + rc, 64'd1 << (i + j));
      end

    // R7: operand order
    for (int n = 0; n < 200; n++) begin
      logic [WB-1:0] x, y;
      logic [63:0] first;
      x = $urandom; y = $urandom;
      drive(x, y);
      first = rs + rc;
      drive(y, x);
      chk("R7 swap", rs + rc, first);
    end

    // R1: random pairs
    for (int n = 0; n < 3000; n++) mul_chk("R1 random", $urandom, $urandom);

    // R1, R4, R5: exhaustive sweep of the 8-bit configuration
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++) begin
        logic [2*WS-1:0] ssum;
        @(posedge clk);
        sa = WS'(i); sb = WS'(j);
        @(negedge clk);
        ssum = srs + src;
        chk("R1 small exhaustive", 64'(ssum), 64'(i * j));
        chk("R4 small", {63'b0, src[0]}, 64'd0);
        chk("R5 small", {63'b0, srs[0]}, {63'b0, sa[0] & sb[0]});
      end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule